// File: doc/BRIEF.md
# Bidirectional GPIO Port with Address-Bus Override

This block is one 8-bit general-purpose I/O port on a microcontroller peripheral bus. A write-only direction register sets each pin to input or output on its own. A data register holds the output latch, and a single option bit turns on the pins' pull-ups. Software reaches all three through a small register bus, which has a write strobe, a read strobe, a 2-bit register select and 8-bit data.

When the memory-expansion control input is high, the port stops acting as GPIO. All pins then drive the upper byte of the internal address bus, whatever the direction register holds. Port reads return the level each pin carries: the address byte, the latch value, or the external input. The pad, its drive strength and the pull-up resistor live outside this block. The block only produces the per-pin output-enable, output-data and pull-up-enable signals, and it samples the per-pin input.

Top module: `gpio_port_ah`

## Requirements
- R1: After reset every direction bit is 1 (input), so with expansion off `pin_oe` is 0. The pull-up option bit is 0. The output latch is not initialised.
- R2: Direction bit i = 1 makes pin i an input (`pin_oe[i]`=0). Direction bit i = 0 makes pin i an output (`pin_oe[i]`=1, `pin_out[i]` = latch bit i). Each bit acts independently of the others.
- R3: The direction register is loaded only by a whole-byte write with select 1. A read with select 1 returns 8'hFF and leaves the register unchanged.
- R4: A write with select 0 loads the output latch at the clock edge, whatever the direction bits and the expansion input are. The stored value appears on a pin once that pin is set to output.
- R5: While `exp_en` is 1, `pin_oe` is all ones and `pin_out` equals `addr_hi`, regardless of the direction register.
- R6: A read with select 0 returns, per bit, `addr_hi` while `exp_en` is 1. Otherwise it returns the latch bit for output pins and `pin_in` for input pins.
- R7: Select 2 holds the pull-up option in bit 0 and reads back as {7'b0, option}. `pin_pu[i]` = option AND (pin i is input) AND NOT `exp_en`.
- R8: `bus_rdata` is zero while `bus_rd` is low. Select 3 reads as zero, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 2 | Register select: 0 data, 1 direction, 2 pull-up option, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| addr_hi | input | 8 | Upper byte of the internal address bus |
| exp_en | input | 1 | Memory-expansion mode active |
| pin_in | input | 8 | Pin levels from the pads |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output data |
| pin_pu | output | 8 | Per-pin pull-up enable |

## Verification
A data-register write can land in the same cycle that expansion mode is active. The bench writes the latch while `exp_en` is high. It checks that the pins and a port read keep showing `addr_hi`, and then that the new latch value appears as soon as `exp_en` falls. A direction write can also share a cycle with a port read. Because the read path is combinational, the bench checks that the read before the edge still reflects the old direction, and that the next read reflects the new one.

// File: rtl/gpio_port_ah_pkg.sv
package gpio_port_ah_pkg;
   localparam int SEL_W = 2;
   typedef enum logic [SEL_W-1:0] {
      SEL_DATA = 2'd0,
      SEL_DIR  = 2'd1,
      SEL_PUO  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/gpio_port_ah_cfg.sv
module gpio_port_ah_cfg
   import gpio_port_ah_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  reg_sel_e         sel,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] dir_q,
   output logic             pu_q
);
   localparam logic [WIDTH-1:0] ALL_IN = {WIDTH{1'b1}};

   logic dir_we;
   logic pu_we;

   assign dir_we = wr && (sel == SEL_DIR);
   assign pu_we  = wr && (sel == SEL_PUO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= ALL_IN;
         pu_q  <= 1'b0;
      end else begin
         if (dir_we) dir_q <= wdata;
         if (pu_we)  pu_q  <= wdata[0];
      end
   end

   AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == SEL_DIR) |=> (dir_q == $past(wdata)));            // R3
   AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && sel == SEL_DIR) |=> $stable(dir_q));                     // R3
   AST_PU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && sel == SEL_PUO) |=> $stable(pu_q));                      // R8
endmodule

// File: rtl/gpio_port_ah_latch.sv
module gpio_port_ah_latch #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] latch_q
);
   always_ff @(posedge clk) begin
      if (we) latch_q <= wdata;
   end

   AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (latch_q == $past(wdata)));                               // R4
endmodule

// File: rtl/gpio_port_ah_pins.sv
module gpio_port_ah_pins #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] latch_q,
   input  logic             pu_q,
   input  logic             exp_en,
   input  logic [WIDTH-1:0] addr_hi,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_pu,
   output logic [WIDTH-1:0] port_view
);
   localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic is_in;
      assign is_in        = dir_q[i];
      assign pin_oe[i]    = exp_en | ~is_in;
      assign pin_out[i]   = exp_en ? addr_hi[i] : latch_q[i];
      assign pin_pu[i]    = pu_q & is_in & ~exp_en;
      assign port_view[i] = exp_en ? addr_hi[i] : (is_in ? pin_in[i] : latch_q[i]);
   end

   AST_EXP_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
      exp_en |-> (pin_oe == ONES && pin_out == addr_hi));              // R5
   AST_PU_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_pu & pin_oe) == '0);                                        // R7
endmodule

// File: rtl/gpio_port_ah.sv
module gpio_port_ah
   import gpio_port_ah_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [1:0]       bus_sel,
   input  logic [WIDTH-1:0] bus_wdata,
   output logic [WIDTH-1:0] bus_rdata,
   input  logic [WIDTH-1:0] addr_hi,
   input  logic             exp_en,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_pu
);
   localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("gpio_port_ah: WIDTH out of range");
   end

   reg_sel_e         sel;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] port_view;
   logic             pu_q;

   assign sel = reg_sel_e'(bus_sel);

   gpio_port_ah_cfg #(.WIDTH(WIDTH)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(sel),
      .wdata(bus_wdata), .dir_q(dir_q), .pu_q(pu_q)
   );

   gpio_port_ah_latch #(.WIDTH(WIDTH)) u_latch (
      .clk(clk), .rst_n(rst_n), .we(bus_wr && sel == SEL_DATA),
      .wdata(bus_wdata), .latch_q(latch_q)
   );

   gpio_port_ah_pins #(.WIDTH(WIDTH)) u_pins (
      .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .latch_q(latch_q),
      .pu_q(pu_q), .exp_en(exp_en), .addr_hi(addr_hi), .pin_in(pin_in),
      .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu),
      .port_view(port_view)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         unique case (sel)
            SEL_DATA: bus_rdata = port_view;
            SEL_DIR:  bus_rdata = ONES;
            SEL_PUO:  bus_rdata = {{(WIDTH-1){1'b0}}, pu_q};
            SEL_NONE: bus_rdata = '0;
         endcase
      end
   end

   AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0));                                  // R8
   AST_DIR_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_sel == 2'd1) |-> (bus_rdata == ONES));            // R3
   AST_EXP_READ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_sel == 2'd0 && exp_en) |-> (bus_rdata == addr_hi)); // R6
endmodule

// File: tb/gpio_port_ah_test.sv
module gpio_port_ah_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [1:0] bus_sel = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [7:0] addr_hi = 8'h00;
   logic       exp_en = 1'b0;
   logic [7:0] pin_in = 8'h00;
   logic [7:0] pin_oe, pin_out, pin_pu;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   gpio_port_ah uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .addr_hi(addr_hi), .exp_en(exp_en), .pin_in(pin_in),
      .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [7:0] d);
      @(negedge clk);
      bus_sel = s; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      @(negedge clk);
      chk("R1 oe after reset", pin_oe, 8'h00);
      chk("R1 pu off after reset", pin_pu, 8'h00);
      rd(2'd2, v);
      chk("R1 pull-up option cleared", v, 8'h00);
   endtask

   task automatic t_direction();
      wr(2'd0, 8'hC3);
      wr(2'd1, 8'h0F);
      @(negedge clk); #1;
      chk("R2 oe from direction", pin_oe, 8'hF0);
      chk("R2 output pins carry latch", pin_out & pin_oe, 8'hC0);
      wr(2'd1, 8'hA5);
      @(negedge clk); #1;
      chk("R2 independent bits", pin_oe, 8'h5A);
   endtask

   task automatic t_dir_readback();
      logic [7:0] v;
      rd(2'd1, v);
      chk("R3 direction reads ones", v, 8'hFF);
      @(negedge clk); #1;
      chk("R3 read leaves direction", pin_oe, 8'h5A);
   endtask

   task automatic t_latch_hidden();
      wr(2'd1, 8'hFF);
      wr(2'd0, 8'h96);
      @(negedge clk); #1;
      chk("R4 inputs stay off", pin_oe, 8'h00);
      wr(2'd1, 8'h00);
      @(negedge clk); #1;
      chk("R4 latch shows on output", pin_out, 8'h96);
      chk("R2 all output", pin_oe, 8'hFF);
   endtask

   task automatic t_port_read();
      logic [7:0] v;
      wr(2'd0, 8'h3C);
      wr(2'd1, 8'hF0);
      pin_in = 8'hA6;
      rd(2'd0, v);
      chk("R6 mixed read", v, 8'hAC);
   endtask

   task automatic t_expansion();
      logic [7:0] v;
      addr_hi = 8'h7E; exp_en = 1'b1;
      #1;
      chk("R5 exp oe", pin_oe, 8'hFF);
      chk("R5 exp out", pin_out, 8'h7E);
      rd(2'd0, v);
      chk("R6 exp read", v, 8'h7E);
      addr_hi = 8'h81; #1;
      chk("R5 exp tracks address", pin_out, 8'h81);
      exp_en = 1'b0; #1;
      chk("R5 direction back after exp", pin_oe, 8'h0F);
   endtask

   task automatic t_pullup();
      logic [7:0] v;
      wr(2'd2, 8'hFF);
      rd(2'd2, v);
      chk("R7 option reads bit0", v, 8'h01);
      #1 chk("R7 pull-ups on inputs", pin_pu, 8'hF0);
      exp_en = 1'b1; #1;
      chk("R7 pull-ups off in exp", pin_pu, 8'h00);
      exp_en = 1'b0;
      wr(2'd2, 8'hFE);
      #1 chk("R7 option cleared", pin_pu, 8'h00);
   endtask

   task automatic t_unused();
      logic [7:0] v;
      wr(2'd3, 8'h55);
      rd(2'd3, v);
      chk("R8 unused select reads zero", v, 8'h00);
      #1 chk("R8 unused write keeps oe", pin_oe, 8'h0F);
      chk("R8 unused write keeps pu", pin_pu, 8'h00);
      chk("R8 unused write keeps latch", pin_out & pin_oe, 8'h0C);
      @(negedge clk); #1;
      chk("R8 idle rdata zero", bus_rdata, 8'h00);
   endtask

   task automatic t_same_cycle();
      logic [7:0] v;
      addr_hi = 8'h24; exp_en = 1'b1;
      wr(2'd0, 8'hE7);
      #1 chk("R5 pins keep address during write", pin_out, 8'h24);
      rd(2'd0, v);
      chk("R6 read keeps address", v, 8'h24);
      exp_en = 1'b0; #1;
      chk("R4 latch written under exp", pin_out & pin_oe, 8'h07);
      pin_in = 8'h00;
      @(negedge clk);
      bus_sel = 2'd1; bus_wdata = 8'hFF; bus_wr = 1'b1;
      #1;
      bus_sel = 2'd1;
      @(negedge clk);
      bus_wr = 1'b0; bus_sel = 2'd0; bus_rd = 1'b1;
      #1 chk("R3 direction write applied", bus_rdata, 8'h00);
      @(negedge clk);
      bus_rd = 1'b0;
      wr(2'd1, 8'h00);
      @(negedge clk);
      bus_sel = 2'd1; bus_wdata = 8'hFF; bus_wr = 1'b1;
      bus_rd = 1'b0;
      #1 chk("R2 old direction before edge", pin_oe, 8'hFF);
      @(negedge clk);
      bus_wr = 1'b0;
      #1 chk("R2 new direction after edge", pin_oe, 8'h00);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_direction();
      t_dir_readback();
      t_latch_hidden();
      t_port_read();
      t_expansion();
      t_pullup();
      t_unused();
      t_same_cycle();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule